// File: doc/BRIEF.md
# Edge-Coverage Counter Engine

This block carries out the edge-coverage update used by coverage-guided fuzzers as a fixed hardware dataflow. A host issues a command holding a 64-bit branch tag. The engine combines that tag with the previous tag, which it holds in an on-chip register, to form a 16-bit slot index. It then reads the counter byte at that slot of a bitmap in memory, adds one to it and writes it back. Finally it makes the new tag the previous tag.

Memory is reached through a single tagged request port and a response channel that cannot push back. The engine has two requesters, the read and the write. They share the port in a fixed order, and the write is held back until the read data has returned. A second command code loads the bitmap base address. The engine raises a busy flag for as long as an update is in flight.

Top module: `cov_edge_engine`

## Requirements
- R1: After reset, busy is low, cmd_ready is high, mreq_valid is low and the previous-tag register holds zero. The first update after reset therefore uses the slot index tag[15:0].
- R2: A command accepted with cmd_func = 0 loads cmd_data into the bitmap base register. It does not raise busy and issues no memory request.
- R3: A command accepted with cmd_func = 1 issues a read. The read has mreq_addr = base + (((prev >> 1) ^ tag) & 0xFFFF), mreq_write = 0, mreq_tag = 0 and mreq_size = 4. The size code is 4 OR log2(bytes), so a one-byte access uses 4.
- R4: While mreq_valid is high and mreq_ready is low, mreq_valid stays high on the next cycle and mreq_addr, mreq_write, mreq_tag and mreq_wdata do not change.
- R5: A response counts as the read result only when three things hold: the read has been accepted, mresp_tag = 0, and mresp_write = 0. Any other response has no effect on the value written back. The result is taken in the same cycle that mresp_valid is high.
- R6: The write uses the same address as the read, with mreq_write = 1, mreq_tag = 1 and mreq_size = 4. Its mreq_wdata[7:0] is the read byte plus one, wrapping from 0xFF to 0x00, and its upper data bits are zero. No write is issued before the read result has been taken.
- R7: When the write is accepted, the previous-tag register takes the command's tag. The next update's index is therefore built from that tag.
- R8: busy rises on the edge that accepts an update command and falls on the edge that accepts its write. While busy is high, cmd_ready is low and no command is taken. While busy is low, mreq_valid is low.
- R9: Each request's mreq_valid rises on the first clock edge after the request becomes eligible. The read becomes eligible on the command acceptance edge. The write becomes eligible on the edge that takes the read result.
- R10: A command accepted with any other cmd_func value has no effect: busy stays low, no request is issued and the base register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_func | input | 7 | Command function code (0 set base, 1 update) |
| cmd_data | input | 64 | Base address or branch tag |
| busy | output | 1 | Update in flight |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted when high with valid |
| mreq_addr | output | 64 | Request byte address |
| mreq_write | output | 1 | 1 write, 0 read |
| mreq_tag | output | 2 | Request tag (0 read, 1 write) |
| mreq_size | output | 3 | Access size code |
| mreq_wdata | output | 64 | Write data |
| mresp_valid | input | 1 | Response valid, no back-pressure |
| mresp_tag | input | 2 | Response tag |
| mresp_write | input | 1 | Response belongs to a write |
| mresp_data | input | 64 | Response data |

## Verification
The checker assumes that the memory side never answers before the request it belongs to has been accepted, and that at most one matching read response arrives per update. The bench sends each good response only after the read handshake has completed. The misleading responses it injects carry the wrong tag or the write flag. It also holds cmd_valid low during an update, except for one deliberate attempt that must be refused.

// File: rtl/cov_edge_pkg.sv
package cov_edge_pkg;
   localparam int unsigned FUNC_W = 7;

   typedef enum logic [FUNC_W-1:0] {
      FN_SET_BASE = 7'd0,
      FN_EDGE     = 7'd1
   } cov_func_e;

   // requester order on the shared memory port: earlier slot wins
   localparam int unsigned SLOT_LOAD  = 0;
   localparam int unsigned SLOT_STORE = 1;
   localparam int unsigned NUM_SLOTS  = 2;

   localparam logic [2:0] SIZE_FLAG = 3'b100;
endpackage

// File: rtl/cov_index_unit.sv
module cov_index_unit #(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned IDX_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [XLEN-1:0]  tag_in,
   input  logic             commit,
   output logic [IDX_W-1:0] index
);
   logic [XLEN-1:0] prev_q;
   logic [XLEN-1:0] tag_q;
   logic [XLEN-1:0] mix;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         tag_q  <= '0;
      end else begin
         if (capture) tag_q  <= tag_in;
         if (commit)  prev_q <= tag_q;
      end
   end

   assign mix   = (prev_q >> 1) ^ tag_q;
   assign index = mix[IDX_W-1:0];
endmodule

// File: rtl/cov_port_arbiter.sv
module cov_port_arbiter #(
   parameter int unsigned NREQ = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active,
   input  logic [NREQ-1:0] want,
   input  logic            fire,
   output logic [NREQ-1:0] grant
);
   logic [NREQ:0]   prior_any;
   logic [NREQ-1:0] cand;

   assign prior_any[0] = 1'b0;

   for (genvar i = 0; i < NREQ; i++) begin : g_slot
      logic en_q, en, gnt_q, ret_q, retire, won;

      assign en     = (want[i] | en_q) & active;
      assign retire = gnt_q & fire;
      assign cand[i] = en & ~ret_q & ~retire;
      assign won    = cand[i] & ~prior_any[i];
      assign prior_any[i+1] = prior_any[i] | cand[i];
      assign grant[i] = gnt_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q  <= 1'b0;
            gnt_q <= 1'b0;
            ret_q <= 1'b0;
         end else if (active) begin
            en_q <= en;
            if (won) gnt_q <= 1'b1;
            if (retire) begin
               gnt_q <= 1'b0;
               ret_q <= 1'b1;
            end
         end else begin
            en_q  <= 1'b0;
            gnt_q <= 1'b0;
            ret_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cov_load_capture.sv
module cov_load_capture #(
   parameter int unsigned XLEN     = 64,
   parameter int unsigned MTAG_W   = 2,
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned LOAD_TAG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              sent_fire,
   input  logic              resp_valid,
   input  logic [MTAG_W-1:0] resp_tag,
   input  logic              resp_write,
   input  logic [XLEN-1:0]   resp_data,
   output logic              ld_valid,
   output logic [CNT_W-1:0]  ld_value
);
   logic sent_q;
   logic hit;

   assign hit = active & sent_q & ~ld_valid & resp_valid & ~resp_write
              & (resp_tag == MTAG_W'(LOAD_TAG));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sent_q   <= 1'b0;
         ld_valid <= 1'b0;
         ld_value <= '0;
      end else if (active) begin
         if (sent_fire) sent_q <= 1'b1;
         if (hit) begin
            ld_valid <= 1'b1;
            ld_value <= resp_data[CNT_W-1:0];
         end
      end else begin
         sent_q   <= 1'b0;
         ld_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/cov_edge_engine.sv
module cov_edge_engine
   import cov_edge_pkg::*;
#(
   parameter int unsigned XLEN   = 64,
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned IDX_W  = 16,
   parameter int unsigned MTAG_W = 2,
   parameter int unsigned CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [6:0]        cmd_func,
   input  logic [XLEN-1:0]   cmd_data,
   output logic              busy,
   output logic              mreq_valid,
   input  logic              mreq_ready,
   output logic [ADDR_W-1:0] mreq_addr,
   output logic              mreq_write,
   output logic [MTAG_W-1:0] mreq_tag,
   output logic [2:0]        mreq_size,
   output logic [XLEN-1:0]   mreq_wdata,
   input  logic              mresp_valid,
   input  logic [MTAG_W-1:0] mresp_tag,
   input  logic              mresp_write,
   input  logic [XLEN-1:0]   mresp_data
);
   localparam int unsigned ACC_LG = $clog2(CNT_W / 8);
   localparam logic [MTAG_W-1:0] LD_TAG = MTAG_W'(SLOT_LOAD);
   localparam logic [MTAG_W-1:0] ST_TAG = MTAG_W'(SLOT_STORE);

   if (IDX_W > XLEN || IDX_W > ADDR_W) begin : g_bad_idx
      $error("IDX_W must fit both XLEN and ADDR_W");
   end
   if ((CNT_W % 8) != 0 || CNT_W > XLEN || CNT_W > 64) begin : g_bad_cnt
      $error("CNT_W must be a whole number of bytes up to 64 and no wider than XLEN");
   end
   if ((1 << MTAG_W) < NUM_SLOTS) begin : g_bad_tag
      $error("MTAG_W too narrow for the requester count");
   end

   logic                 computing_q;
   logic                 accept, is_edge, is_base, fire, done;
   logic [ADDR_W-1:0]    base_q;
   logic [IDX_W-1:0]     index;
   logic [NUM_SLOTS-1:0] want, grant;
   logic                 ld_valid;
   logic [CNT_W-1:0]     ld_value, cnt_next;

   assign cmd_ready = ~computing_q;
   assign busy      = computing_q;
   assign accept    = cmd_valid & cmd_ready;
   assign is_edge   = accept & (cmd_func == FN_EDGE);
   assign is_base   = accept & (cmd_func == FN_SET_BASE);
   assign fire      = mreq_valid & mreq_ready;
   assign done      = grant[SLOT_STORE] & fire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         computing_q <= 1'b0;
         base_q      <= '0;
      end else begin
         if (is_base) base_q <= ADDR_W'(cmd_data);
         if (is_edge)   computing_q <= 1'b1;
         else if (done) computing_q <= 1'b0;
      end
   end

   cov_index_unit #(.XLEN(XLEN), .IDX_W(IDX_W)) u_index (
      .clk    (clk),
      .rst_n  (rst_n),
      .capture(is_edge),
      .tag_in (cmd_data),
      .commit (done),
      .index  (index)
   );

   assign want[SLOT_LOAD]  = 1'b1;
   assign want[SLOT_STORE] = ld_valid;

   cov_port_arbiter #(.NREQ(NUM_SLOTS)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .active(computing_q),
      .want  (want),
      .fire  (fire),
      .grant (grant)
   );

   cov_load_capture #(
      .XLEN(XLEN), .MTAG_W(MTAG_W), .CNT_W(CNT_W), .LOAD_TAG(SLOT_LOAD)
   ) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (computing_q),
      .sent_fire (grant[SLOT_LOAD] & fire),
      .resp_valid(mresp_valid),
      .resp_tag  (mresp_tag),
      .resp_write(mresp_write),
      .resp_data (mresp_data),
      .ld_valid  (ld_valid),
      .ld_value  (ld_value)
   );

   assign cnt_next   = ld_value + {{(CNT_W-1){1'b0}}, 1'b1};
   assign mreq_valid = |grant;
   assign mreq_addr  = base_q + {{(ADDR_W-IDX_W){1'b0}}, index};
   assign mreq_write = grant[SLOT_STORE];
   assign mreq_tag   = grant[SLOT_STORE] ? ST_TAG : LD_TAG;
   assign mreq_size  = SIZE_FLAG | 3'(ACC_LG);

   if (XLEN > CNT_W) begin : g_pad
      assign mreq_wdata = {{(XLEN-CNT_W){1'b0}}, cnt_next};
   end else begin : g_full
      assign mreq_wdata = cnt_next;
   end
endmodule

// File: rtl/cov_edge_engine_chk.sv
module cov_edge_engine_chk #(
   parameter int unsigned XLEN   = 64,
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned IDX_W  = 16,
   parameter int unsigned MTAG_W = 2,
   parameter int unsigned CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [6:0]        cmd_func,
   input logic [XLEN-1:0]   cmd_data,
   input logic              busy,
   input logic              mreq_valid,
   input logic              mreq_ready,
   input logic [ADDR_W-1:0] mreq_addr,
   input logic              mreq_write,
   input logic [MTAG_W-1:0] mreq_tag,
   input logic [2:0]        mreq_size,
   input logic [XLEN-1:0]   mreq_wdata,
   input logic              mresp_valid,
   input logic [MTAG_W-1:0] mresp_tag,
   input logic              mresp_write,
   input logic [XLEN-1:0]   mresp_data
);
   logic             seen_q;
   logic [CNT_W-1:0] seen_val;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy) begin
         seen_q   <= 1'b0;
         seen_val <= '0;
      end else if (mresp_valid && !mresp_write && mresp_tag == '0 && !seen_q) begin
         seen_q   <= 1'b1;
         seen_val <= mresp_data[CNT_W-1:0];
      end
   end

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr) && $stable(mreq_write)
                                    && $stable(mreq_tag) && $stable(mreq_wdata));
   assert_size_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid |-> mreq_size == 3'd4);
   assert_store_after_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid && mreq_write |-> seen_q);
   assert_store_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_valid && mreq_write |-> mreq_wdata == XLEN'(CNT_W'(seen_val + 1'b1)));
   assert_no_cmd_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cmd_ready);
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mreq_valid);
   assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(mreq_valid && mreq_ready && mreq_write));
endmodule

bind cov_edge_engine cov_edge_engine_chk #(
   .XLEN(XLEN), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .MTAG_W(MTAG_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/tb_cov_edge_engine.sv
module tb_cov_edge_engine;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_valid;
   logic        cmd_ready;
   logic [6:0]  cmd_func;
   logic [63:0] cmd_data;
   logic        busy;
   logic        mreq_valid;
   logic        mreq_ready;
   logic [63:0] mreq_addr;
   logic        mreq_write;
   logic [1:0]  mreq_tag;
   logic [2:0]  mreq_size;
   logic [63:0] mreq_wdata;
   logic        mresp_valid;
   logic [1:0]  mresp_tag;
   logic        mresp_write;
   logic [63:0] mresp_data;

   int checks = 0;
   int failures = 0;
   logic [63:0] base_m = '0;
   logic [63:0] prev_m = '0;

   always #10 clk = ~clk;

   cov_edge_engine dut (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; cmd_valid = 0; cmd_func = '0; cmd_data = '0; mreq_ready = 0;
      mresp_valid = 0; mresp_tag = '0; mresp_write = 0; mresp_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b0, "R1", "busy", 64'(busy), 0);
      chk(cmd_ready == 1'b1, "R1", "cmd_ready", 64'(cmd_ready), 1);
      chk(mreq_valid == 1'b0, "R1", "mreq_valid", 64'(mreq_valid), 0);
   endtask

   task automatic t_cmd(input logic [6:0] func, input logic [63:0] data, input string req);
      cmd_valid = 1; cmd_func = func; cmd_data = data;
      @(negedge clk);
      cmd_valid = 0;
      chk(busy == 1'b0, req, "busy after non-update cmd", 64'(busy), 0);
      chk(mreq_valid == 1'b0, req, "no request", 64'(mreq_valid), 0);
      @(negedge clk);
      chk(mreq_valid == 1'b0 && busy == 1'b0, req, "still idle", 64'(mreq_valid), 0);
      if (func == 7'd0) base_m = data;
   endtask

   task automatic t_edge(input logic [63:0] tag, input logic [7:0] val,
                         input int stall, input int dly, input bit junk);
      logic [63:0] exp_addr;
      exp_addr = base_m + (((prev_m >> 1) ^ tag) & 64'hFFFF);
      cmd_valid = 1; cmd_func = 7'd1; cmd_data = tag;
      chk(cmd_ready == 1'b1, "R8", "ready before cmd", 64'(cmd_ready), 1);
      @(negedge clk);
      cmd_valid = 0;
      chk(busy == 1'b1, "R8", "busy after accept", 64'(busy), 1);
      chk(mreq_valid == 1'b0, "R9", "load not yet granted", 64'(mreq_valid), 0);
      if (junk) begin cmd_valid = 1; cmd_func = 7'd0; cmd_data = 64'hDEAD_0000; end
      @(negedge clk);
      if (junk) chk(cmd_ready == 1'b0, "R8", "ready while busy", 64'(cmd_ready), 0);
      cmd_valid = 0;
      chk(mreq_valid == 1'b1, "R9", "load valid", 64'(mreq_valid), 1);
      chk(mreq_addr == exp_addr, "R3", "load addr", mreq_addr, exp_addr);
      chk(mreq_write == 1'b0 && mreq_tag == 2'd0, "R3", "load kind/tag",
          {mreq_write, mreq_tag}, 0);
      chk(mreq_size == 3'd4, "R3", "load size", 64'(mreq_size), 4);
      for (int k = 0; k < stall; k++) begin
         @(negedge clk);
         chk(mreq_valid && mreq_addr == exp_addr && !mreq_write, "R4", "load held",
             mreq_addr, exp_addr);
      end
      mreq_ready = 1;
      @(negedge clk);
      mreq_ready = 0;
      for (int k = 0; k < dly; k++) begin
         chk(mreq_valid == 1'b0, "R6", "no store before data", 64'(mreq_valid), 0);
         if (junk && k == 0) begin
            mresp_valid = 1; mresp_tag = 2'd1; mresp_write = 0; mresp_data = 64'h33;
         end else if (junk && k == 1) begin
            mresp_valid = 1; mresp_tag = 2'd0; mresp_write = 1; mresp_data = 64'h44;
         end else mresp_valid = 0;
         @(negedge clk);
      end
      mresp_valid = 1; mresp_tag = 2'd0; mresp_write = 0;
      mresp_data = {56'hA5C3_F00D_1234_99, val};
      @(negedge clk);
      mresp_valid = 0;
      chk(mreq_valid == 1'b0, "R9", "store not yet granted", 64'(mreq_valid), 0);
      @(negedge clk);
      chk(mreq_valid == 1'b1 && mreq_write == 1'b1, "R9", "store valid",
          {mreq_valid, mreq_write}, 64'h3);
      chk(mreq_addr == exp_addr, "R6", "store addr", mreq_addr, exp_addr);
      chk(mreq_wdata == {56'h0, 8'(val + 8'd1)}, "R5", "store data", mreq_wdata,
          {56'h0, 8'(val + 8'd1)});
      chk(mreq_tag == 2'd1 && mreq_size == 3'd4, "R6", "store tag/size",
          {mreq_tag, mreq_size}, {2'd1, 3'd4});
      chk(busy == 1'b1, "R8", "busy during store", 64'(busy), 1);
      for (int k = 0; k < stall; k++) begin
         @(negedge clk);
         chk(mreq_valid && mreq_write && mreq_addr == exp_addr, "R4", "store held",
             mreq_addr, exp_addr);
      end
      mreq_ready = 1;
      @(negedge clk);
      mreq_ready = 0;
      chk(busy == 1'b0 && cmd_ready == 1'b1, "R8", "idle after store",
          {busy, cmd_ready}, 64'h1);
      chk(mreq_valid == 1'b0, "R8", "quiet after store", 64'(mreq_valid), 0);
      prev_m = tag;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL R8 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_cmd(7'd0, 64'h0000_0000_8000_0000, "R2");
      // R1: previous tag is zero, index = tag low bits
      t_edge(64'h0000_0000_0000_1234, 8'h10, 0, 1, 1'b0);
      // R7: index now built from 0x1234
      t_edge(64'hABCD_0000_0000_F00F, 8'h7E, 2, 3, 1'b0);
      // R5/R6 wrap with junk responses and a refused command
      t_edge(64'h0000_0000_0055_0000, 8'hFF, 1, 3, 1'b1);
      t_cmd(7'd3, 64'h1111_2222_3333_4444, "R10");
      t_edge(64'h0000_0000_0000_00AA, 8'h00, 0, 2, 1'b0);
      t_cmd(7'd0, 64'h0000_0001_0000_0000, "R2");
      t_edge(64'hFFFF_FFFF_FFFF_FFFF, 8'h80, 1, 1, 1'b0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule